// File: doc/BRIEF.md
# Processor Debug-Mode Supervisor with Hardware Break Comparators

This block sits beside a processor core and decides when the core is running normally, when it is in debug mode, and when it has stopped for good. The core reports decoded events to it: a break instruction, a return-from-trap with a one-bit operand, and the current trap-enable flag. The block enters debug mode on a break instruction or on a hit from one of its hardware comparators. It leaves debug mode only on the one legal return variant. Every misuse of a return stops the core.

Four instruction comparators watch the fetch address. Two data comparators watch the data access address and a two-lane data value, and each lane has its own data and mask register. A comparator hit in normal mode raises a one-cycle debug trap on vector 255 and records a one-hot cause. The debug register file can be written only while debug mode is active, so code running normally cannot move its own breakpoints.

Top module: `dbg_supervisor`

## Requirements
- R1: After reset the block is in normal mode with the halt and trap outputs low, the trap vector at 0, the cause field at 0, and every debug register reading 0, so all comparators are disabled.
- R2: In normal mode, a break instruction with no return in the same cycle enters debug mode at the next edge, clears the cause field and raises no trap.
- R3: While in debug mode, break instructions and comparator hits have no effect: the mode, the trap output and the cause field stay as they were.
- R4: A register write is applied only in debug mode. In normal or halted mode it is discarded. The select values are: 0 for control (bit i enables instruction comparator i, bit 4+j enables data comparator j), 1 to 4 for instruction addresses, 5 and 6 for data addresses, 7 + 2j + k for the data value of comparator j lane k, and 11 + 2j + k for its mask. Reads of selects 15 and up return 0.
- R5: A return with operand 1 and traps disabled, issued in debug mode, returns to normal mode at the next edge.
- R6: A return with operand 0 and traps disabled, issued in debug mode, keeps debug mode.
- R7: Any return issued while traps are enabled goes to the halted state. A return with operand 1 issued in normal mode also halts. A return with operand 0 and traps disabled in normal mode changes nothing.
- R8: The halted state holds until reset, whatever the events, hits or writes.
- R9: Instruction comparator i hits when its enable bit is set, the fetch is valid and the fetch address equals its address register. In normal mode a hit enters debug mode and sets cause bit i.
- R10: Data comparator j hits when its enable bit is set, the access is valid, the address equals its address register, and for each lane k (data bits [8k+7:8k] at the bench width) the data equals the lane's value register in every bit whose mask bit is 0. A mask bit of 1 means don't care. A hit sets cause bit 4+j.
- R11: Within a cycle a return takes precedence over a break, and a break over comparator hits. Among simultaneous hits the lowest cause index wins, so the cause field is always one-hot or zero.
- R12: A hardware entry raises the trap output for exactly one cycle, in the cycle debug mode first shows, with the vector output at 255. At all other times the vector output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| brk_insn | input | 1 | Break instruction executed this cycle |
| rett_insn | input | 1 | Return-from-trap executed this cycle |
| rett_op | input | 1 | Operand of the return (0 or 1) |
| trap_en | input | 1 | Current trap-enable flag of the core |
| fetch_vld | input | 1 | Fetch address valid |
| fetch_addr | input | ADDR_W | Fetch address |
| dacc_vld | input | 1 | Data access valid |
| dacc_addr | input | ADDR_W | Data access address |
| dacc_data | input | NUM_LANE*DATA_W | Data access value, lane k in bits [k*DATA_W +: DATA_W] |
| dreg_wr | input | 1 | Debug register write strobe |
| dreg_sel | input | SEL_W | Debug register write select |
| dreg_wdata | input | DATA_W | Debug register write data |
| dreg_rsel | input | SEL_W | Debug register read select |
| dreg_rdata | output | DATA_W | Debug register read data (combinational) |
| dbg_active | output | 1 | Debug mode active |
| core_halt | output | 1 | Core halted (sticky) |
| dbg_trap | output | 1 | One-cycle hardware debug trap |
| dbg_trap_vec | output | 8 | Trap vector, 255 while the trap is raised |
| hit_status | output | NUM_IBRK+NUM_DBRK | One-hot cause of the latest hardware entry |

## Verification
The bench builds the block with four instruction comparators, two data comparators of two lanes each, and 8-bit addresses and data. At these widths random fetch and access addresses, half of them drawn from the programmed registers, hit the comparators often. This brings simultaneous hits, partial mask matches and lane mismatches within reach of a few thousand random cycles. Directed cases cover the exit and stay returns, returns with traps enabled, returns in normal mode, break-versus-return precedence and the sticky halt.

// File: rtl/dbg_sup_pkg.sv
package dbg_sup_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_DEBUG  = 2'd1,
    MODE_HALTED = 2'd2
  } dbg_mode_e;

  localparam int          TRAP_VEC_W = 8;
  localparam logic [7:0]  HW_TRAP_VEC = 8'd255;

endpackage

// File: rtl/dbg_regfile.sv
module dbg_regfile #(
  parameter int NI    = 4,
  parameter int ND    = 2,
  parameter int NL    = 2,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int SEL_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_allow,
  input  logic                          wr,
  input  logic [SEL_W-1:0]              sel,
  input  logic [DW-1:0]                 wdata,
  input  logic [SEL_W-1:0]              rd_sel,
  output logic [DW-1:0]                 rd_data,
  output logic [NI+ND-1:0]              ctrl,
  output logic [NI-1:0][AW-1:0]         ibar,
  output logic [ND-1:0][AW-1:0]         dbar,
  output logic [ND-1:0][NL-1:0][DW-1:0] dbdr,
  output logic [ND-1:0][NL-1:0][DW-1:0] dbmr
);

  localparam int IBAR_BASE = 1;
  localparam int DBAR_BASE = IBAR_BASE + NI;
  localparam int DBDR_BASE = DBAR_BASE + ND;
  localparam int DBMR_BASE = DBDR_BASE + ND * NL;
  localparam int NREG      = DBMR_BASE + ND * NL;

  logic [NREG-1:0][DW-1:0] regs_q, regs_d;
  logic [NREG-1:0]         we;

  // write enables and next-state
  always_comb begin
    regs_d = regs_q;
    for (int r = 0; r < NREG; r++) begin
      we[r] = wr_allow && wr && (sel == SEL_W'(r));
      if (we[r]) regs_d[r] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) regs_q <= '0;
    else if (|we) regs_q <= regs_d;
  end

  always_comb begin
    rd_data = '0;
    for (int r = 0; r < NREG; r++)
      if (rd_sel == SEL_W'(r)) rd_data = regs_q[r];
  end

  assign ctrl = regs_q[0][NI+ND-1:0];

  for (genvar i = 0; i < NI; i++) begin : g_ibar
    assign ibar[i] = regs_q[IBAR_BASE+i][AW-1:0];
  end

  for (genvar j = 0; j < ND; j++) begin : g_dcmp_regs
    assign dbar[j] = regs_q[DBAR_BASE+j][AW-1:0];
    for (genvar k = 0; k < NL; k++) begin : g_lane
      assign dbdr[j][k] = regs_q[DBDR_BASE + j*NL + k];
      assign dbmr[j][k] = regs_q[DBMR_BASE + j*NL + k];
    end
  end

  AST_WR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_allow |=> $stable(regs_q)); // R4

endmodule

// File: rtl/dbg_icmp.sv
module dbg_icmp #(
  parameter int NI = 4,
  parameter int AW = 32
) (
  input  logic                  fetch_vld,
  input  logic [AW-1:0]         fetch_addr,
  input  logic [NI-1:0]         en,
  input  logic [NI-1:0][AW-1:0] addr,
  output logic [NI-1:0]         hit
);

  for (genvar i = 0; i < NI; i++) begin : g_cmp
    assign hit[i] = en[i] && fetch_vld && (fetch_addr == addr[i]);
  end

endmodule

// File: rtl/dbg_dcmp.sv
module dbg_dcmp #(
  parameter int ND = 2,
  parameter int NL = 2,
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic                          dacc_vld,
  input  logic [AW-1:0]                 dacc_addr,
  input  logic [NL*DW-1:0]              dacc_data,
  input  logic [ND-1:0]                 en,
  input  logic [ND-1:0][AW-1:0]         dbar,
  input  logic [ND-1:0][NL-1:0][DW-1:0] dbdr,
  input  logic [ND-1:0][NL-1:0][DW-1:0] dbmr,
  output logic [ND-1:0]                 hit
);

  for (genvar j = 0; j < ND; j++) begin : g_cmp
    logic [NL-1:0] lane_ok;
    for (genvar k = 0; k < NL; k++) begin : g_lane
      // mask bit 1 = don't care
      assign lane_ok[k] = ((dacc_data[k*DW +: DW] ^ dbdr[j][k]) & ~dbmr[j][k]) == '0;
    end
    assign hit[j] = en[j] && dacc_vld && (dacc_addr == dbar[j]) && (&lane_ok);
  end

endmodule

// File: rtl/dbg_mode_fsm.sv
module dbg_mode_fsm
  import dbg_sup_pkg::*;
#(
  parameter int NHIT = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            brk_insn,
  input  logic            rett_insn,
  input  logic            rett_op,
  input  logic            trap_en,
  input  logic [NHIT-1:0] hit,
  output dbg_mode_e       mode,
  output logic            trap,
  output logic [NHIT-1:0] cause
);

  dbg_mode_e       state_q, state_d;
  logic            trap_q, trap_d;
  logic [NHIT-1:0] cause_q, cause_d;
  logic [NHIT-1:0] first_hit;

  // lowest index wins
  always_comb begin
    first_hit = '0;
    for (int i = NHIT - 1; i >= 0; i--) begin
      if (hit[i]) begin
        first_hit    = '0;
        first_hit[i] = 1'b1;
      end
    end
  end

  always_comb begin
    state_d = state_q;
    trap_d  = 1'b0;
    cause_d = cause_q;
    unique case (state_q)
      MODE_NORMAL: begin
        if (rett_insn) begin
          if (trap_en || rett_op) state_d = MODE_HALTED;
        end else if (brk_insn) begin
          state_d = MODE_DEBUG;
          cause_d = '0;
        end else if (|hit) begin
          state_d = MODE_DEBUG;
          trap_d  = 1'b1;
          cause_d = first_hit;
        end
      end
      MODE_DEBUG: begin
        if (rett_insn) begin
          if (trap_en)      state_d = MODE_HALTED;
          else if (rett_op) state_d = MODE_NORMAL;
        end
      end
      MODE_HALTED: state_d = MODE_HALTED;
      default:     state_d = MODE_HALTED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MODE_NORMAL;
      trap_q  <= 1'b0;
      cause_q <= '0;
    end else begin
      state_q <= state_d;
      trap_q  <= trap_d;
      cause_q <= cause_d;
    end
  end

  assign mode  = state_q;
  assign trap  = trap_q;
  assign cause = cause_q;

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == MODE_HALTED |=> state_q == MODE_HALTED); // R8
  AST_DBG_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MODE_DEBUG && rett_insn && !trap_en && rett_op) |=> state_q == MODE_NORMAL); // R5
  AST_DBG_STAY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MODE_DEBUG && rett_insn && !trap_en && !rett_op) |=> state_q == MODE_DEBUG); // R6
  AST_RETT_TE_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (rett_insn && trap_en) |=> state_q == MODE_HALTED); // R7
  AST_BRK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MODE_NORMAL && !rett_insn && brk_insn) |=> (cause_q == '0 && !trap_q)); // R2
  AST_DBG_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MODE_DEBUG && !rett_insn) |=> ($stable(cause_q) && !trap_q)); // R3
  AST_TRAP_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    trap_q |=> !trap_q); // R12
  AST_TRAP_IN_DBG: assert property (@(posedge clk) disable iff (!rst_n)
    trap_q |-> state_q == MODE_DEBUG); // R9
  AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cause_q)); // R11

endmodule

// File: rtl/dbg_supervisor.sv
module dbg_supervisor
  import dbg_sup_pkg::*;
#(
  parameter int NUM_IBRK = 4,
  parameter int NUM_DBRK = 2,
  parameter int NUM_LANE = 2,
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  localparam int NUM_REG = 1 + NUM_IBRK + NUM_DBRK + 2 * NUM_DBRK * NUM_LANE,
  localparam int SEL_W   = $clog2(NUM_REG + 1),
  localparam int NHIT    = NUM_IBRK + NUM_DBRK
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         brk_insn,
  input  logic                         rett_insn,
  input  logic                         rett_op,
  input  logic                         trap_en,
  input  logic                         fetch_vld,
  input  logic [ADDR_W-1:0]            fetch_addr,
  input  logic                         dacc_vld,
  input  logic [ADDR_W-1:0]            dacc_addr,
  input  logic [NUM_LANE*DATA_W-1:0]   dacc_data,
  input  logic                         dreg_wr,
  input  logic [SEL_W-1:0]             dreg_sel,
  input  logic [DATA_W-1:0]            dreg_wdata,
  input  logic [SEL_W-1:0]             dreg_rsel,
  output logic [DATA_W-1:0]            dreg_rdata,
  output logic                         dbg_active,
  output logic                         core_halt,
  output logic                         dbg_trap,
  output logic [TRAP_VEC_W-1:0]        dbg_trap_vec,
  output logic [NHIT-1:0]              hit_status
);

  // reset release synchronizer
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  dbg_mode_e                                     mode;
  logic [NHIT-1:0]                               ctrl;
  logic [NUM_IBRK-1:0][ADDR_W-1:0]               ibar;
  logic [NUM_DBRK-1:0][ADDR_W-1:0]               dbar;
  logic [NUM_DBRK-1:0][NUM_LANE-1:0][DATA_W-1:0] dbdr;
  logic [NUM_DBRK-1:0][NUM_LANE-1:0][DATA_W-1:0] dbmr;
  logic [NUM_IBRK-1:0]                           ihit;
  logic [NUM_DBRK-1:0]                           dhit;
  logic                                          trap;

  dbg_regfile #(
    .NI(NUM_IBRK), .ND(NUM_DBRK), .NL(NUM_LANE),
    .AW(ADDR_W), .DW(DATA_W), .SEL_W(SEL_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_allow(mode == MODE_DEBUG),
    .wr      (dreg_wr),
    .sel     (dreg_sel),
    .wdata   (dreg_wdata),
    .rd_sel  (dreg_rsel),
    .rd_data (dreg_rdata),
    .ctrl    (ctrl),
    .ibar    (ibar),
    .dbar    (dbar),
    .dbdr    (dbdr),
    .dbmr    (dbmr)
  );

  dbg_icmp #(.NI(NUM_IBRK), .AW(ADDR_W)) u_icmp (
    .fetch_vld (fetch_vld),
    .fetch_addr(fetch_addr),
    .en        (ctrl[NUM_IBRK-1:0]),
    .addr      (ibar),
    .hit       (ihit)
  );

  dbg_dcmp #(.ND(NUM_DBRK), .NL(NUM_LANE), .AW(ADDR_W), .DW(DATA_W)) u_dcmp (
    .dacc_vld (dacc_vld),
    .dacc_addr(dacc_addr),
    .dacc_data(dacc_data),
    .en       (ctrl[NHIT-1:NUM_IBRK]),
    .dbar     (dbar),
    .dbdr     (dbdr),
    .dbmr     (dbmr),
    .hit      (dhit)
  );

  dbg_mode_fsm #(.NHIT(NHIT)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .brk_insn (brk_insn),
    .rett_insn(rett_insn),
    .rett_op  (rett_op),
    .trap_en  (trap_en),
    .hit      ({dhit, ihit}),
    .mode     (mode),
    .trap     (trap),
    .cause    (hit_status)
  );

  assign dbg_active   = (mode == MODE_DEBUG);
  assign core_halt    = (mode == MODE_HALTED);
  assign dbg_trap     = trap;
  assign dbg_trap_vec = trap ? HW_TRAP_VEC : '0;

  AST_VEC_ONLY_TRAP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !dbg_trap |-> dbg_trap_vec == '0); // R12
  AST_NO_DBG_HALT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(dbg_active && core_halt)); // R8

endmodule

// File: tb/dbg_supervisor_bench.sv
`timescale 1ns/1ps
module dbg_supervisor_bench;

  localparam int NI = 4, ND = 2, NL = 2, AW = 8, DW = 8;
  localparam int NREG = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic brk_insn, rett_insn, rett_op, trap_en, fetch_vld, dacc_vld, dreg_wr;
  logic [AW-1:0] fetch_addr, dacc_addr;
  logic [NL*DW-1:0] dacc_data;
  logic [3:0] dreg_sel, dreg_rsel;
  logic [DW-1:0] dreg_wdata, dreg_rdata;
  logic dbg_active, core_halt, dbg_trap;
  logic [7:0] dbg_trap_vec;
  logic [5:0] hit_status;

  always #2 clk = ~clk;

  dbg_supervisor #(.NUM_IBRK(NI), .NUM_DBRK(ND), .NUM_LANE(NL), .ADDR_W(AW), .DATA_W(DW))
  u_dbg_supervisor (
    .clk(clk), .rst_n(rst_n), .brk_insn(brk_insn), .rett_insn(rett_insn), .rett_op(rett_op),
    .trap_en(trap_en), .fetch_vld(fetch_vld), .fetch_addr(fetch_addr), .dacc_vld(dacc_vld),
    .dacc_addr(dacc_addr), .dacc_data(dacc_data), .dreg_wr(dreg_wr), .dreg_sel(dreg_sel),
    .dreg_wdata(dreg_wdata), .dreg_rsel(dreg_rsel), .dreg_rdata(dreg_rdata),
    .dbg_active(dbg_active), .core_halt(core_halt), .dbg_trap(dbg_trap),
    .dbg_trap_vec(dbg_trap_vec), .hit_status(hit_status)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // reference model: 0 normal, 1 debug, 2 halted
  int         m_mode;
  logic [7:0] m_regs [NREG];
  logic [5:0] m_stat;
  logic       m_trap;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] model_hits();
    logic [5:0] h = '0;
    for (int i = 0; i < NI; i++)
      h[i] = m_regs[0][i] && fetch_vld && (fetch_addr == m_regs[1+i]);
    for (int j = 0; j < ND; j++) begin
      logic ok = m_regs[0][NI+j] && dacc_vld && (dacc_addr == m_regs[5+j]);
      for (int k = 0; k < NL; k++)
        if (((dacc_data[k*DW +: DW] ^ m_regs[7+j*NL+k]) & ~m_regs[11+j*NL+k]) != 8'h00) ok = 1'b0;
      h[NI+j] = ok;
    end
    return h;
  endfunction

  function automatic logic [5:0] lowest(input logic [5:0] h);
    for (int i = 0; i < 6; i++) if (h[i]) return 6'(1 << i);
    return '0;
  endfunction

  function automatic logic [31:0] expected_out();
    logic [7:0] rd = (dreg_rsel < NREG) ? m_regs[dreg_rsel] : 8'h00;
    return {7'd0, m_mode == 1, m_mode == 2, m_trap, (m_trap ? 8'hFF : 8'h00), m_stat, rd};
  endfunction

  function automatic logic [31:0] actual_out();
    return {7'd0, dbg_active, core_halt, dbg_trap, dbg_trap_vec, hit_status, dreg_rdata};
  endfunction

  task automatic idle();
    brk_insn = 0; rett_insn = 0; rett_op = 0; trap_en = 0; fetch_vld = 0; dacc_vld = 0;
    dreg_wr = 0; fetch_addr = '0; dacc_addr = '0; dacc_data = '0; dreg_sel = '0;
    dreg_wdata = '0;
  endtask

  // one clock: model next state from current inputs, then compare
  task automatic step(input string req);
    logic [5:0] h = model_hits();
    int nm = m_mode;
    logic [5:0] ns = m_stat;
    logic nt = 1'b0;
    if (m_mode == 0) begin
      if (rett_insn) begin
        if (trap_en || rett_op) nm = 2;
      end else if (brk_insn) begin
        nm = 1; ns = '0;
      end else if (h != 0) begin
        nm = 1; nt = 1'b1; ns = lowest(h);
      end
    end else if (m_mode == 1) begin
      if (rett_insn) begin
        if (trap_en) nm = 2;
        else if (rett_op) nm = 0;
      end
    end
    if (m_mode == 1 && dreg_wr && dreg_sel < NREG) m_regs[dreg_sel] = dreg_wdata;
    m_mode = nm; m_stat = ns; m_trap = nt;
    @(posedge clk); #1;
    chk(req, actual_out(), expected_out());
  endtask

  task automatic do_reset();
    idle();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    m_mode = 0; m_stat = '0; m_trap = 1'b0;
    for (int r = 0; r < NREG; r++) m_regs[r] = '0;
  endtask

  task automatic wr_reg(input logic [3:0] s, input logic [7:0] v, input string req);
    idle(); dreg_wr = 1; dreg_sel = s; dreg_wdata = v; dreg_rsel = s; step(req);
  endtask

  function automatic string rand_tag();
    if (m_mode == 2) return "R8";
    if (rett_insn) return trap_en ? "R7" : (m_mode == 1 ? (rett_op ? "R5" : "R6") : "R7");
    if (m_mode == 1) return "R3";
    if (brk_insn) return "R2";
    if (dacc_vld) return "R10";
    return "R9";
  endfunction

  initial begin
    #700000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    dreg_rsel = '0;
    do_reset();
    // R1 reset state and register contents
    for (int r = 0; r < 16; r += 5) begin
      dreg_rsel = 4'(r); #1;
      chk("R1", actual_out(), 32'h0);
    end

    // R4 write in normal mode discarded
    wr_reg(4'd1, 8'h5A, "R4");
    chk("R4", {24'd0, dreg_rdata}, 32'h0);
    // R2 break enters debug
    idle(); brk_insn = 1; step("R2");
    chk("R2", {31'd0, dbg_active}, 32'd1);
    // R3 break ignored in debug
    idle(); brk_insn = 1; step("R3");
    wr_reg(4'd1, 8'h40, "R4");
    wr_reg(4'd0, 8'h01, "R4");
    chk("R4", {24'd0, dreg_rdata}, 32'h01);
    // R3 hit ignored in debug
    idle(); fetch_vld = 1; fetch_addr = 8'h40; step("R3");
    chk("R3", {31'd0, dbg_trap}, 32'd0);
    // R6 stay, R5 exit
    idle(); rett_insn = 1; step("R6");
    chk("R6", {31'd0, dbg_active}, 32'd1);
    idle(); rett_insn = 1; rett_op = 1; step("R5");
    chk("R5", {31'd0, dbg_active}, 32'd0);
    // R9 instruction hit, R12 trap pulse
    idle(); fetch_vld = 1; fetch_addr = 8'h41; step("R9");
    idle(); fetch_vld = 1; fetch_addr = 8'h40; step("R9");
    chk("R12", {dbg_trap_vec, 2'b0, hit_status}, {8'hFF, 8'h01});
    idle(); step("R12");
    chk("R12", {31'd0, dbg_trap}, 32'd0);
    // program data comparator 1
    wr_reg(4'd6,  8'h20, "R4");
    wr_reg(4'd9,  8'h33, "R4");
    wr_reg(4'd10, 8'hC0, "R4");
    wr_reg(4'd13, 8'h0F, "R4");
    wr_reg(4'd14, 8'h00, "R4");
    wr_reg(4'd0,  8'h21, "R4");
    idle(); rett_insn = 1; rett_op = 1; step("R5");
    // R10 mismatch in a cared bit, then masked match
    idle(); dacc_vld = 1; dacc_addr = 8'h20; dacc_data = {8'hC0, 8'h43}; step("R10");
    chk("R10", {31'd0, dbg_active}, 32'd0);
    idle(); dacc_vld = 1; dacc_addr = 8'h20; dacc_data = {8'hC0, 8'h3A}; step("R10");
    chk("R10", {26'd0, hit_status}, 32'h20);
    idle(); rett_insn = 1; rett_op = 1; step("R5");
    // R11 simultaneous hits: lowest index
    idle(); fetch_vld = 1; fetch_addr = 8'h40; dacc_vld = 1; dacc_addr = 8'h20;
    dacc_data = {8'hC0, 8'h33}; step("R11");
    chk("R11", {26'd0, hit_status}, 32'h01);
    idle(); rett_insn = 1; rett_op = 1; step("R5");
    // R7 harmless return in normal, R11 return beats break
    idle(); rett_insn = 1; step("R7");
    idle(); rett_insn = 1; brk_insn = 1; step("R11");
    chk("R11", {31'd0, dbg_active}, 32'd0);
    // R4 write in normal discarded
    wr_reg(4'd0, 8'h00, "R4");
    chk("R4", {24'd0, dreg_rdata}, 32'h21);
    // R7 return with traps enabled halts; R8 sticky
    idle(); rett_insn = 1; trap_en = 1; step("R7");
    idle(); brk_insn = 1; step("R8");
    idle(); rett_insn = 1; rett_op = 1; step("R8");
    idle(); fetch_vld = 1; fetch_addr = 8'h40; step("R8");
    wr_reg(4'd0, 8'h00, "R8");
    chk("R8", {31'd0, core_halt}, 32'd1);
    // R7 exit return from normal halts
    do_reset();
    idle(); rett_insn = 1; rett_op = 1; step("R7");
    chk("R7", {31'd0, core_halt}, 32'd1);
    // R7 traps enabled in debug halts
    do_reset();
    idle(); brk_insn = 1; step("R2");
    idle(); rett_insn = 1; rett_op = 1; trap_en = 1; step("R7");
    chk("R7", {31'd0, core_halt}, 32'd1);

    // constrained random
    do_reset();
    for (int n = 0; n < 5000; n++) begin
      idle();
      brk_insn   = ($urandom % 8) == 0;
      rett_insn  = ($urandom % 12) == 0;
      rett_op    = 1'($urandom);
      trap_en    = ($urandom % 6) == 0;
      fetch_vld  = 1'($urandom);
      fetch_addr = ($urandom % 2) ? m_regs[1 + $urandom % 4] : 8'($urandom);
      dacc_vld   = 1'($urandom);
      dacc_addr  = ($urandom % 2) ? m_regs[5 + $urandom % 2] : 8'($urandom);
      dacc_data  = ($urandom % 2) ? {m_regs[10] ^ 8'($urandom % 4), m_regs[9]}
                                  : 16'($urandom);
      dreg_wr    = ($urandom % 3) == 0;
      dreg_sel   = 4'($urandom);
      dreg_wdata = 8'($urandom);
      dreg_rsel  = 4'($urandom);
      step(rand_tag());
      if (m_mode == 2 && ($urandom % 4) == 0) do_reset();
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule